// File: doc/BRIEF.md
# Ping-Pong DMA Buffer Descriptor

This block keeps the descriptor state of one DMA channel as two alternating buffer slots. Each slot holds a current source address and a remaining byte count. When the memory-to-memory option is built in, each slot also holds a current destination address. Software fills a slot through a small register write port. Writing a non-zero byte count arms the slot. The transfer engine then works through the armed slot that the active pointer selects, one accepted beat at a time. Each beat moves the slot's addresses forward and takes bytes off its count.

When the active slot's count runs out, the slot is disarmed and the pointer moves to the other slot. A one-cycle completion pulse and a sticky status bit mark the event, so the interrupt logic can ask software to refill the slot that just finished. Software can reload one slot while the engine drains the other, so the channel only stops when software has fallen a whole buffer behind. In that case the engine request drops and a sticky stall bit is set. The channel resumes as soon as the slot it is waiting on is armed.

Top module: `pp_dma_desc`

## Requirements
- R1: After a synchronous reset, both slots are unarmed, slot 0 is active, the status bits and done pulses are zero, and `eng_req` is low.
- R2: A write of a non-zero count to an unarmed slot loads the count and arms the slot on the next cycle. A zero count leaves the slot unarmed. The count register is address 1 for slot 0 and address 3 for slot 1, and it takes the low 16 bits of the data.
- R3: While a slot is armed, writes to its source address, destination address or count have no effect. The source address is at address 0 or 2, and the destination address is at address 4 or 5, for slot 0 or slot 1.
- R4: Each accepted beat on the active armed slot advances its source address by the beat size and lowers its count by the same amount, stopping at zero. The size code maps 0 to 1 byte, 1 to 2 bytes, and both 2 and 3 to 4 bytes.
- R5: The beat that empties the active slot disarms it and moves the active pointer to the other slot. It also raises `done_pulse` for exactly one cycle, with bit 0 for slot 0 and bit 1 for slot 1.
- R6: If the other slot is unarmed when a slot completes, status bit 2 is set and `eng_req` goes low. Arming the waiting slot raises `eng_req` again.
- R7: A count write that arms the other slot in the same cycle as a completion prevents the stall.
- R8: Status bit 0 records a slot 0 completion, bit 1 a slot 1 completion, and bit 2 a stall. Writing ones to address 6 clears the selected bits. A new event in the same cycle wins over the clear. `irq` is high whenever any status bit is set.
- R9: A beat that arrives while `eng_req` is low changes no address, count, pointer or status.
- R10: The destination address of the active slot advances by the same byte step as the source address on each accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | DW (32) | Write data |
| eng_beat | input | 1 | Engine accepted one beat this cycle |
| eng_size | input | 2 | Beat size code |
| eng_req | output | 1 | Active slot is armed; engine may transfer |
| cur_src | output | AW (32) | Current source address of the active slot |
| cur_dst | output | AW (32) | Current destination address of the active slot |
| cur_cnt | output | CW (16) | Remaining bytes of the active slot |
| active_slot | output | 1 | Index of the active slot |
| slot_valid | output | 2 | Armed flag per slot |
| done_pulse | output | 2 | One-cycle completion pulse per slot |
| status | output | 3 | Sticky completion and stall bits |
| irq | output | 1 | Any status bit set |

## Verification
The assertions check the following on every cycle:
- an armed slot never holds a zero count;
- an armed slot that receives no beat keeps its registers;
- at most one slot advances at a time;
- the pointer changes exactly on completions;
- a stall always drops the request on the next cycle.

The scenarios in the bench are needed for the rest. Only they show that the step sizes and count clipping are right. Only they show that a refill in the same cycle as a completion avoids the stall, and that set wins over clear in the status register. They also show that the register values stay correct across many random completions, refills and ignored writes, because the bench compares them against its own model.

// File: rtl/pp_desc_pkg.sv
package pp_desc_pkg;

  localparam logic [2:0] A_SRC0 = 3'd0;
  localparam logic [2:0] A_CNT0 = 3'd1;
  localparam logic [2:0] A_SRC1 = 3'd2;
  localparam logic [2:0] A_CNT1 = 3'd3;
  localparam logic [2:0] A_DST0 = 3'd4;
  localparam logic [2:0] A_DST1 = 3'd5;
  localparam logic [2:0] A_STS  = 3'd6;

  localparam int STS_W = 3;

  // Byte step for an engine size code: 0 -> 1, 1 -> 2, 2 and 3 -> 4
  function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction

  // Count after a beat, stopping at zero
  function automatic logic [15:0] cnt_after(input logic [15:0] cnt, input logic [2:0] step);
    if (cnt <= 16'(step)) cnt_after = '0;
    else                  cnt_after = cnt - 16'(step);
  endfunction

endpackage

// File: rtl/pp_slot.sv
module pp_slot
  import pp_desc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int DW      = 32,
  parameter bit HAS_DST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [DW-1:0] wr_data,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          valid,
  output logic          load,
  output logic          finish
);

  logic          move;
  logic [CW-1:0] new_cnt;

  assign move    = adv && valid;
  assign load    = wr_cnt && !valid && (wr_data[CW-1:0] != '0);
  assign finish  = move && (cnt <= CW'(step));
  assign new_cnt = finish ? '0 : (cnt - CW'(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cnt   <= wr_data[CW-1:0];
    end else if (move) begin
      cnt <= new_cnt;
      if (finish) valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  src <= '0;
    else if (wr_src && !valid) src <= wr_data[AW-1:0];
    else if (move)            src <= src + AW'(step);
  end

  generate
    if (HAS_DST) begin : g_dst
      always_ff @(posedge clk) begin
        if (rst)                  dst <= '0;
        else if (wr_dst && !valid) dst <= wr_data[AW-1:0];
        else if (move)            dst <= dst + AW'(step);
      end
    end else begin : g_no_dst
      assign dst = '0;
    end
  endgenerate

  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (rst)
    valid |-> (cnt != '0)); // R2

  AST_ARMED_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (valid && !adv) |=> ($stable(cnt) && $stable(src) && $stable(dst))); // R3

  AST_DISARM_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
    finish |=> !valid); // R5

endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_desc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [1:0]       valid,
  input  logic [1:0]       load,
  input  logic [1:0]       fin_slot,
  input  logic             wr_sts,
  input  logic [STS_W-1:0] clr_bits,
  output logic             active,
  output logic [1:0]       adv,
  output logic [1:0]       done_pulse,
  output logic [STS_W-1:0] status,
  output logic             stall_evt
);

  logic             fin;
  logic             other;
  logic [STS_W-1:0] set_bits;
  logic [STS_W-1:0] clr_mask;

  assign other     = ~active;
  assign adv[0]    = beat && !active && valid[0];
  assign adv[1]    = beat &&  active && valid[1];
  assign fin       = |fin_slot;
  assign stall_evt = fin && !(valid[other] || load[other]);
  assign set_bits  = {stall_evt, fin_slot};
  assign clr_mask  = wr_sts ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      done_pulse <= '0;
      status     <= '0;
    end else begin
      if (fin) active <= other;
      done_pulse <= fin_slot;
      status     <= (status & ~clr_mask) | set_bits;
    end
  end

  AST_ADV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adv)); // R4

  AST_FLIP_ON_FIN: assert property (@(posedge clk) disable iff (rst)
    fin |=> (active != $past(active))); // R5

  AST_HOLD_NO_FIN: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(active)); // R5

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_pulse)); // R5

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    stall_evt |=> status[2]); // R6

endmodule

// File: rtl/pp_dma_desc.sv
module pp_dma_desc
  import pp_desc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int DW      = 32,
  parameter bit HAS_DST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_beat,
  input  logic [1:0]    eng_size,
  output logic          eng_req,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic          active_slot,
  output logic [1:0]    slot_valid,
  output logic [1:0]    done_pulse,
  output logic [2:0]    status,
  output logic          irq
);

  localparam int NSLOT = 2;

  logic [2:0]    step;
  logic [1:0]    adv;
  logic [1:0]    load;
  logic [1:0]    fin_slot;
  logic          stall_evt;
  logic [AW-1:0] s_src [NSLOT];
  logic [AW-1:0] s_dst [NSLOT];
  logic [CW-1:0] s_cnt [NSLOT];

  assign step = beat_bytes(eng_size);

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam logic [2:0] SA = (i == 0) ? A_SRC0 : A_SRC1;
      localparam logic [2:0] CA = (i == 0) ? A_CNT0 : A_CNT1;
      localparam logic [2:0] DA = (i == 0) ? A_DST0 : A_DST1;

      pp_slot #(.AW(AW), .CW(CW), .DW(DW), .HAS_DST(HAS_DST)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .wr_src (wr_en && (wr_addr == SA)),
        .wr_dst (wr_en && (wr_addr == DA)),
        .wr_cnt (wr_en && (wr_addr == CA)),
        .wr_data(wr_data),
        .adv    (adv[i]),
        .step   (step),
        .src    (s_src[i]),
        .dst    (s_dst[i]),
        .cnt    (s_cnt[i]),
        .valid  (slot_valid[i]),
        .load   (load[i]),
        .finish (fin_slot[i])
      );
    end
  endgenerate

  pp_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .beat      (eng_beat),
    .valid     (slot_valid),
    .load      (load),
    .fin_slot  (fin_slot),
    .wr_sts    (wr_en && (wr_addr == A_STS)),
    .clr_bits  (wr_data[STS_W-1:0]),
    .active    (active_slot),
    .adv       (adv),
    .done_pulse(done_pulse),
    .status    (status),
    .stall_evt (stall_evt)
  );

  assign cur_src = s_src[active_slot];
  assign cur_dst = s_dst[active_slot];
  assign cur_cnt = s_cnt[active_slot];
  assign eng_req = slot_valid[active_slot];
  assign irq     = |status;

  AST_STALL_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    stall_evt |=> !eng_req); // R6

  AST_IDLE_BEAT_INERT: assert property (@(posedge clk) disable iff (rst)
    (!eng_req && !wr_en) |=> ($stable(cur_cnt) && $stable(active_slot) && $stable(status))); // R9

endmodule

// File: tb/test_pp_dma_desc.sv
`timescale 1ns/1ps
module test_pp_dma_desc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        eng_beat = 1'b0;
  logic [1:0]  eng_size = '0;
  logic        eng_req;
  logic [31:0] cur_src, cur_dst;
  logic [15:0] cur_cnt;
  logic        active_slot;
  logic [1:0]  slot_valid, done_pulse;
  logic [2:0]  status;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench-side model of the descriptor
  logic [31:0] m_src [2];
  logic [31:0] m_dst [2];
  logic [15:0] m_cnt [2];
  logic [1:0]  m_val;
  logic        m_act;
  logic [1:0]  m_done;
  logic [2:0]  m_sts;

  always #2 clk = ~clk;

  pp_dma_desc i_pp_dma_desc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_beat(eng_beat), .eng_size(eng_size), .eng_req(eng_req),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .active_slot(active_slot), .slot_valid(slot_valid), .done_pulse(done_pulse),
    .status(status), .irq(irq)
  );

  function automatic int bytes_of(input logic [1:0] sz);
    return (sz >= 2'd2) ? 4 : int'(sz) + 1;
  endfunction

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0;
    end
    m_val = '0; m_act = 1'b0; m_done = '0; m_sts = '0;
  endtask

  task automatic model_step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                            input logic bt, input logic [1:0] sz);
    int          st;
    int          a;
    logic        adv, fin, stall;
    logic [1:0]  ld;
    logic [1:0]  old_val;
    logic [2:0]  clr;
    st      = bytes_of(sz);
    a       = int'(m_act);
    old_val = m_val;
    adv     = bt && old_val[a];
    fin     = adv && (int'(m_cnt[a]) <= st);
    ld[0]   = we && wa == 3'd1 && !old_val[0] && wd[15:0] != 16'd0;
    ld[1]   = we && wa == 3'd3 && !old_val[1] && wd[15:0] != 16'd0;
    stall   = fin && !(old_val[1-a] || ld[1-a]);
    clr     = (we && wa == 3'd6) ? wd[2:0] : 3'b000;
    for (int i = 0; i < 2; i++) begin
      logic [2:0] sa, da;
      sa = (i == 0) ? 3'd0 : 3'd2;
      da = (i == 0) ? 3'd4 : 3'd5;
      if (we && wa == sa && !old_val[i]) m_src[i] = wd;
      else if (adv && i == a)            m_src[i] = m_src[i] + 32'(st);
      if (we && wa == da && !old_val[i]) m_dst[i] = wd;
      else if (adv && i == a)            m_dst[i] = m_dst[i] + 32'(st);
      if (ld[i]) begin
        m_cnt[i] = wd[15:0]; m_val[i] = 1'b1;
      end else if (adv && i == a) begin
        m_cnt[i] = fin ? 16'd0 : m_cnt[i] - 16'(st);
        if (fin) m_val[i] = 1'b0;
      end
    end
    m_done = fin ? ((a == 1) ? 2'b10 : 2'b01) : 2'b00;
    m_sts  = (m_sts & ~clr) | {stall, fin && a == 1, fin && a == 0};
    if (fin) m_act = ~m_act;
  endtask

  task automatic compare();
    int a;
    a = int'(m_act);
    chk("R5", "active_slot", active_slot, m_act);
    chk("R2", "slot_valid", slot_valid, m_val);
    chk("R4", "cur_src", cur_src, m_src[a]);
    chk("R4", "cur_cnt", cur_cnt, m_cnt[a]);
    chk("R10", "cur_dst", cur_dst, m_dst[a]);
    chk("R5", "done_pulse", done_pulse, m_done);
    chk("R8", "status", status, m_sts);
    chk("R8", "irq", irq, |m_sts);
    chk("R6", "eng_req", eng_req, m_val[a]);
  endtask

  // Called at a falling edge: drive, advance model, wait one cycle, compare
  task automatic cyc(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                     input logic bt, input logic [1:0] sz);
    wr_en = we; wr_addr = wa; wr_data = wd; eng_beat = bt; eng_size = sz;
    model_step(we, wa, wd, bt, sz);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] wa, input logic [31:0] wd);
    cyc(1'b1, wa, wd, 1'b0, 2'd0);
  endtask

  task automatic beat(input logic [1:0] sz);
    cyc(1'b0, 3'd0, 32'd0, 1'b1, sz);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "slot_valid", slot_valid, 0);
    chk("R1", "active_slot", active_slot, 0);
    chk("R1", "status", status, 0);
    chk("R1", "eng_req", eng_req, 0);
    compare();

    // R2: zero count does not arm
    wr(3'd1, 32'd0);
    chk("R2", "zero count armed", slot_valid, 2'b00);
    wr(3'd0, 32'h1000);
    wr(3'd4, 32'h8000);
    wr(3'd1, 32'd6);
    chk("R2", "slot0 armed", slot_valid, 2'b01);
    // R3: writes to an armed slot are ignored
    wr(3'd0, 32'h2222);
    wr(3'd1, 32'd99);
    chk("R3", "src locked", cur_src, 32'h1000);
    chk("R3", "cnt locked", cur_cnt, 16'd6);
    // R4: 2-byte beats, then completion with slot 1 empty -> stall (R6)
    beat(2'd1);
    chk("R4", "src +2", cur_src, 32'h1002);
    chk("R10", "dst +2", cur_dst, 32'h8002);
    beat(2'd1);
    beat(2'd1);
    chk("R5", "done pulse slot0", done_pulse, 2'b01);
    chk("R6", "stall bit", status[2], 1);
    chk("R6", "req low", eng_req, 0);
    // R9: beat while idle is ignored
    beat(2'd2);
    chk("R9", "idle cnt", cur_cnt, 16'd0);
    chk("R9", "idle done", done_pulse, 2'b00);
    chk("R9", "idle active", active_slot, 1);
    // R6: arming the waiting slot resumes
    wr(3'd2, 32'h3000);
    wr(3'd3, 32'd4);
    chk("R6", "req resumes", eng_req, 1);
    wr(3'd6, 32'h7);
    chk("R8", "w1c clears", status, 3'b000);
    // R7: completion with same-cycle refill of slot 0
    cyc(1'b1, 3'd1, 32'd8, 1'b1, 2'd2);
    chk("R7", "no stall", status[2], 0);
    chk("R7", "active slot0", active_slot, 0);
    chk("R7", "req", eng_req, 1);
    // R8: set wins over clear; size code 3 is 4 bytes (R4)
    beat(2'd3);
    chk("R4", "code3 step", cur_cnt, 16'd4);
    cyc(1'b1, 3'd6, 32'h7, 1'b1, 2'd3);
    chk("R8", "set over clear", status, 3'b101);
    chk("R8", "irq", irq, 1);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic        we;
      logic [2:0]  wa;
      logic [31:0] wd;
      we = ($urandom % 100) < 35;
      wa = 3'($urandom % 8);
      if (wa == 3'd1 || wa == 3'd3) wd = $urandom % 14;
      else                          wd = $urandom;
      c0 = 16'($urandom % 4);
      cyc(we, wa, wd, ($urandom % 100) < 70, c0[1:0]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule